// File: doc/BRIEF.md
# Byte-Wide Boot ROM Sequencer

This block serves host processor accesses that fall in the top 8 MB of the 32-bit address space, where a byte-wide boot ROM shares the multiplexed PCI address/data lines. The ROM is much narrower than the host bus, so the block answers a host read with repeated byte fetches. It reads eight consecutive ROM bytes starting at the double-word boundary below the request address. Each byte enters a shift register, and the resulting 64-bit word is returned either as one beat or as a four-beat pseudo-burst that repeats the same word.

A host store-word to an even address in the window is a flash programming cycle. The data word itself carries the target location: its upper three bytes form the 24-bit ROM address and its low byte is the value written. The sequencer then pulses the ROM write strobe once. Any other write in the window is rejected with a transfer error.

The ROM device speed is set by a wait-clock parameter. The sequencer stalls while the shared lines are busy with a PCI transaction, keeping every ROM strobe and line driver inactive for that time.

Top module: `boot_rom_seq`

## Requirements
- R1: A request whose address bits [31:23] are not all ones produces no acknowledge, no error and no ROM strobe.
- R2: A read ignores the size code and the low three address bits. It fetches ROM bytes at offsets 0 to 7 from the request address modulo 2^ROM_AW, with bits [2:0] cleared, so a 512 KB device appears repeated every 512 KB inside the window.
- R3: In big-endian mode (`le_mode`=0) the first fetched byte lands in `host_rdata[63:56]` and the eighth in `[7:0]`. With `le_mode`=1 the byte order of the returned word is reversed.
- R4: A single-beat read (`ts_burst`=0) ends with `host_aack` and `host_ta` high together for exactly one clock.
- R5: A burst read (`ts_burst`=1) holds `host_ta` high for four consecutive clocks with unchanged `host_rdata`, and `host_aack` is high only on the fourth.
- R6: A write with size code 4 (byte count), address bit 0 clear and `ts_burst`=0 gives exactly one `rom_we_n` pulse. During the pulse `rom_ad_out[23:0]` equals `ts_wdata[31:8]` and `rom_ad_out[31:24]` equals `ts_wdata[7:0]`, all held stable. The cycle then ends with `host_aack` and `host_ta` for one clock.
- R7: A write with any other size code, an odd address or `ts_burst`=1 ends with `host_tea` and `host_aack` for one clock, without `host_ta` and without any `rom_we_n` pulse.
- R8: While `pci_active` is high, `rom_oe_n` and `rom_we_n` stay high and `rom_ad_oe` stays low. The access resumes afterwards with an unchanged result.
- R9: Without stalls, each ROM byte read keeps `rom_oe_n` low for WAIT_CYC+1 clocks, so a read holds `rom_oe_n` low for 8*(WAIT_CYC+1) clocks in total.
- R10: During and straight after reset, all ROM strobes are high, `rom_ad_oe` is low and no host acknowledge is driven.
- R11: `rom_oe_n` and `rom_we_n` are never low in the same clock, and `host_ta` and `host_tea` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_valid | input | 1 | One-clock transfer start from the host |
| ts_addr | input | 32 | Host byte address |
| ts_write | input | 1 | 1 = write, 0 = read |
| ts_size | input | 4 | Transfer size as a byte count |
| ts_burst | input | 1 | Burst transfer flag |
| ts_wdata | input | 32 | Host store-word data |
| le_mode | input | 1 | Little-endian byte order for read data |
| pci_active | input | 1 | A PCI transaction currently owns the shared lines |
| rom_din | input | 8 | ROM data byte |
| rom_ad_out | output | 32 | Shared lines: [23:0] ROM address, [31:24] write data |
| rom_ad_oe | output | 1 | Drive enable for the shared lines |
| rom_oe_n | output | 1 | ROM read strobe, active low |
| rom_we_n | output | 1 | ROM write strobe, active low |
| host_aack | output | 1 | Address acknowledge |
| host_ta | output | 1 | Transfer acknowledge |
| host_tea | output | 1 | Transfer error acknowledge |
| host_rdata | output | 64 | Assembled read data |

## Verification
The assertions check on every clock the properties that need no knowledge of the request: strobe silence during PCI ownership, mutual exclusion of the strobes and of success and error, a single-clock address acknowledge, the continuity and data stability of a burst, and a write address held stable. Only the bench scenarios show the results that depend on the request. These are the window decode, the alias and alignment of the eight fetched addresses, the byte order in both endian modes, the number of read wait clocks, the split of the write word, and which bad writes are refused. The bench shows them by comparing against a ROM model and expected values computed from the request.

// File: rtl/boot_rom_pkg.sv
package boot_rom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WRITE,
    ST_RESP,
    ST_ERR
  } seq_state_e;

endpackage

// File: rtl/rom_window_decode.sv
module rom_window_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 9,
  parameter int ROM_AW   = 19,
  parameter int WORD_SZ  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        size,
  input  logic              burst,
  output logic              hit,
  output logic              wr_legal,
  output logic [ROM_AW-1:0] rom_base
);
  localparam int LOW_BITS = ADDR_W - WIN_BITS;

  logic unused_mid;

  assign hit      = &addr[ADDR_W-1:LOW_BITS];
  assign wr_legal = (size == 4'(WORD_SZ)) && !addr[0] && !burst;
  // double-word aligned base, high bits dropped so the device aliases
  assign rom_base = {addr[ROM_AW-1:3], 3'b000};
  assign unused_mid = ^addr[LOW_BITS-1:ROM_AW] ^ ^addr[2:1];
endmodule

// File: rtl/rom_shift_asm.sv
module rom_shift_asm #(
  parameter int NBYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic [7:0]          din,
  input  logic                le,
  output logic [NBYTES*8-1:0] dout
);
  localparam int W = NBYTES * 8;

  logic [W-1:0] sr_q, sr_d;
  logic [W-1:0] swapped;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) sr_d = {sr_q[W-9:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (shift_en) sr_q <= sr_d;
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_swap
    assign swapped[g*8 +: 8] = sr_q[(NBYTES-1-g)*8 +: 8];
  end

  assign dout = le ? swapped : sr_q;
endmodule

// File: rtl/rom_seq_ctrl.sv
module rom_seq_ctrl
  import boot_rom_pkg::*;
#(
  parameter int NBYTES   = 8,
  parameter int WAIT_CYC = 2,
  parameter int BEATS    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      hit,
  input  logic                      is_write,
  input  logic                      wr_legal,
  input  logic                      burst_in,
  input  logic                      pci_active,
  output logic                      accept,
  output logic                      in_fetch,
  output logic                      in_write,
  output logic                      shift_en,
  output logic [$clog2(NBYTES)-1:0] byte_idx,
  output logic                      ta,
  output logic                      aack,
  output logic                      tea
);
  localparam int WCW = $clog2(WAIT_CYC + 2);
  localparam int BIW = $clog2(NBYTES);
  localparam int BTW = $clog2(BEATS + 1);

  seq_state_e       state_q, state_d;
  logic [WCW-1:0]   wait_q, wait_d;
  logic [BIW-1:0]   idx_q, idx_d;
  logic [BTW-1:0]   beat_q, beat_d;
  logic             burst_q, burst_d;
  logic             wait_last, step;

  assign wait_last = (wait_q == WCW'(WAIT_CYC));
  assign step      = (state_q == ST_FETCH || state_q == ST_WRITE) && !pci_active;
  assign accept    = start && hit && (state_q == ST_IDLE);

  assign in_fetch = (state_q == ST_FETCH);
  assign in_write = (state_q == ST_WRITE);
  assign shift_en = in_fetch && !pci_active && wait_last;
  assign byte_idx = idx_q;
  assign ta       = (state_q == ST_RESP);
  assign tea      = (state_q == ST_ERR);
  assign aack     = tea || (ta && (!burst_q || beat_q == BTW'(BEATS - 1)));

  always_comb begin
    state_d = state_q;
    wait_d  = wait_q;
    idx_d   = idx_q;
    beat_d  = beat_q;
    burst_d = burst_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          wait_d  = '0;
          idx_d   = '0;
          beat_d  = '0;
          burst_d = burst_in && !is_write;
          if (!is_write)     state_d = ST_FETCH;
          else if (wr_legal) state_d = ST_WRITE;
          else               state_d = ST_ERR;
        end
      end
      ST_FETCH, ST_WRITE: begin
        if (step) begin
          if (wait_last) begin
            wait_d = '0;
            if (state_q == ST_WRITE) state_d = ST_RESP;
            else begin
              idx_d = idx_q + 1'b1;
              if (idx_q == BIW'(NBYTES - 1)) state_d = ST_RESP;
            end
          end else begin
            wait_d = wait_q + 1'b1;
          end
        end
      end
      ST_RESP: begin
        if (aack) state_d = ST_IDLE;
        else      beat_d  = beat_q + 1'b1;
      end
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      idx_q   <= '0;
      beat_q  <= '0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      idx_q   <= idx_d;
      beat_q  <= beat_d;
      burst_q <= burst_d;
    end
  end
endmodule

// File: rtl/boot_rom_seq.sv
module boot_rom_seq #(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 9,
  parameter int ROM_AW   = 19,
  parameter int WAIT_CYC = 2,
  parameter int NBYTES   = 8,
  parameter int BEATS    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ts_valid,
  input  logic [31:0] ts_addr,
  input  logic        ts_write,
  input  logic [3:0]  ts_size,
  input  logic        ts_burst,
  input  logic [31:0] ts_wdata,
  input  logic        le_mode,
  input  logic        pci_active,
  input  logic [7:0]  rom_din,
  output logic [31:0] rom_ad_out,
  output logic        rom_ad_oe,
  output logic        rom_oe_n,
  output logic        rom_we_n,
  output logic        host_aack,
  output logic        host_ta,
  output logic        host_tea,
  output logic [63:0] host_rdata
);
  localparam int BIW    = $clog2(NBYTES);
  localparam int RA_PAD = 24 - ROM_AW;

  logic              hit, wr_legal, accept;
  logic [ROM_AW-1:0] base_d, base_q;
  logic [31:0]       wdata_q;
  logic              le_q;
  logic              in_fetch, in_write, shift_en;
  logic [BIW-1:0]    byte_idx;
  logic [ROM_AW-1:0] fetch_addr;

  rom_window_decode #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .ROM_AW(ROM_AW), .WORD_SZ(4)
  ) u_dec (
    .addr(ts_addr), .size(ts_size), .burst(ts_burst),
    .hit(hit), .wr_legal(wr_legal), .rom_base(base_d)
  );

  rom_seq_ctrl #(
    .NBYTES(NBYTES), .WAIT_CYC(WAIT_CYC), .BEATS(BEATS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(ts_valid), .hit(hit),
    .is_write(ts_write), .wr_legal(wr_legal), .burst_in(ts_burst),
    .pci_active(pci_active), .accept(accept), .in_fetch(in_fetch),
    .in_write(in_write), .shift_en(shift_en), .byte_idx(byte_idx),
    .ta(host_ta), .aack(host_aack), .tea(host_tea)
  );

  rom_shift_asm #(.NBYTES(NBYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(rom_din),
    .le(le_q), .dout(host_rdata)
  );

  // request capture, clock-enabled by acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      wdata_q <= '0;
      le_q    <= 1'b0;
    end else if (accept) begin
      base_q  <= base_d;
      wdata_q <= ts_wdata;
      le_q    <= le_mode;
    end
  end

  assign fetch_addr = base_q | ROM_AW'(byte_idx);

  always_comb begin
    rom_ad_out = '0;
    if (in_write)      rom_ad_out = {wdata_q[7:0], wdata_q[31:8]};
    else if (in_fetch) rom_ad_out = {8'h00, {RA_PAD{1'b0}}, fetch_addr};
  end

  assign rom_ad_oe = (in_fetch || in_write) && !pci_active;
  assign rom_oe_n  = !(in_fetch && !pci_active);
  assign rom_we_n  = !(in_write && !pci_active);
endmodule

// File: rtl/boot_rom_seq_chk.sv
module boot_rom_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pci_active,
  input logic [31:0] rom_ad_out,
  input logic        rom_ad_oe,
  input logic        rom_oe_n,
  input logic        rom_we_n,
  input logic        host_aack,
  input logic        host_ta,
  input logic        host_tea,
  input logic [63:0] host_rdata
);
  AST_PCI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    pci_active |-> (rom_oe_n && rom_we_n && !rom_ad_oe)); // R8

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rom_oe_n && !rom_we_n)); // R11

  AST_OK_XOR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_ta && host_tea)); // R11

  AST_AACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_aack |=> !host_aack); // R4

  AST_BURST_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ta && !host_aack) |=> host_ta); // R5

  AST_BEAT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (host_ta && $past(host_ta)) |-> $stable(host_rdata)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_we_n && $past(!rom_we_n)) |-> $stable(rom_ad_out)); // R6

  AST_ERR_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    host_tea |-> host_aack); // R7
endmodule

bind boot_rom_seq boot_rom_seq_chk u_chk (.*);

// File: tb/boot_rom_seq_test.sv
module boot_rom_seq_test;
  localparam int WAIT_CYC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts_valid = 1'b0;
  logic [31:0] ts_addr = '0;
  logic        ts_write = 1'b0;
  logic [3:0]  ts_size = '0;
  logic        ts_burst = 1'b0;
  logic [31:0] ts_wdata = '0;
  logic        le_mode = 1'b0;
  logic        pci_active = 1'b0;
  logic [7:0]  rom_din;
  logic [31:0] rom_ad_out;
  logic        rom_ad_oe, rom_oe_n, rom_we_n;
  logic        host_aack, host_ta, host_tea;
  logic [63:0] host_rdata;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_byte(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'd0, a[18:16]} ^ 8'h3C;
  endfunction

  function automatic logic [63:0] exp_read(input logic [31:0] addr, input logic le);
    logic [63:0] d;
    logic [18:0] b;
    logic [63:0] s;
    d = '0;
    b = {addr[18:3], 3'b000};
    for (int i = 0; i < 8; i++) d = {d[55:0], rom_byte(b + 19'(i))};
    for (int i = 0; i < 8; i++) s[i*8 +: 8] = d[(7-i)*8 +: 8];
    return le ? s : d;
  endfunction

  assign rom_din = rom_byte(rom_ad_out[18:0]);

  boot_rom_seq #(.WAIT_CYC(WAIT_CYC)) uut (.*);

  // strobe monitor
  int oe_cycles, we_falls, strobe_viol;
  logic we_prev = 1'b1;
  logic [31:0] wr_ad;
  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!rom_oe_n) oe_cycles++;
      if (!rom_we_n && we_prev) begin
        we_falls++;
        wr_ad = rom_ad_out;
      end
      if (pci_active && (!rom_oe_n || !rom_we_n || rom_ad_oe)) strobe_viol++;
    end
    we_prev = rom_we_n;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // stall: 0 none, 1 random PCI activity, 2 PCI busy for the first cycles
  task automatic run_txn(input logic [31:0] addr, input bit wr, input logic [3:0] size,
                         input bit burst, input logic [31:0] wdata, input bit le,
                         input int stall);
    bit hit, legal, seen;
    int ta_n, aack_n, tea_n, aack_at, bad_data, ta_aack_same;
    logic [63:0] exp;
    hit   = (addr[31:23] == 9'h1FF);
    legal = (size == 4'd4) && !addr[0] && !burst;
    exp   = exp_read(addr, le);
    seen = 0; ta_n = 0; aack_n = 0; tea_n = 0; aack_at = 0; bad_data = 0; ta_aack_same = 0;
    @(negedge clk);
    oe_cycles = 0; we_falls = 0;
    if (stall == 2) pci_active = 1'b1;
    ts_addr = addr; ts_write = wr; ts_size = size; ts_burst = burst;
    ts_wdata = wdata; le_mode = le; ts_valid = 1'b1;
    @(negedge clk);
    ts_valid = 1'b0;
    ts_addr = $urandom; ts_size = 4'($urandom); ts_burst = 1'($urandom); le_mode = 1'($urandom);
    for (int c = 0; c < 400; c++) begin
      if (host_ta || host_tea) begin
        seen = 1;
        if (host_tea) tea_n++;
        if (host_aack) aack_n++;
        if (host_ta) begin
          ta_n++;
          if (host_rdata != exp) bad_data++;
          if (host_aack) begin aack_at = ta_n; ta_aack_same++; end
        end
      end else if (seen) begin
        break;
      end
      if (!hit && c >= 50) break;
      if (stall == 1) pci_active = ($urandom % 3 == 0);
      if (stall == 2 && c == 10) pci_active = 1'b0;
      @(negedge clk);
    end
    pci_active = 1'b0;
    if (!hit) begin
      check(!seen, "R1", "response outside window", 64'(seen), 64'd0);
      check(oe_cycles == 0 && we_falls == 0, "R1", "strobe outside window",
            64'(oe_cycles + we_falls), 64'd0);
    end else if (!wr) begin
      check(seen, "R4", "read timed out", 64'(seen), 64'd1);
      check(bad_data == 0 && ta_n > 0, "R3", "read data", host_rdata, exp);
      check(tea_n == 0, "R2", "read size/alignment ignored, no error", 64'(tea_n), 64'd0);
      if (!burst) begin
        check(ta_n == 1 && aack_n == 1 && aack_at == 1, "R4", "single beat ta/aack",
              64'(ta_n * 16 + aack_n), 64'h11);
      end else begin
        check(ta_n == 4 && aack_n == 1 && aack_at == 4, "R5", "burst ta count/aack beat",
              64'(ta_n * 16 + aack_at), 64'h44);
      end
      if (stall == 0)
        check(oe_cycles == 8 * (WAIT_CYC + 1), "R9", "read strobe clocks",
              64'(oe_cycles), 64'(8 * (WAIT_CYC + 1)));
    end else if (legal) begin
      check(we_falls == 1, "R6", "write strobe count", 64'(we_falls), 64'd1);
      check(wr_ad == {wdata[7:0], wdata[31:8]}, "R6", "write address/data split",
            64'(wr_ad), 64'({wdata[7:0], wdata[31:8]}));
      check(ta_n == 1 && aack_n == 1 && tea_n == 0, "R6", "write acknowledge",
            64'(ta_n * 256 + aack_n * 16 + tea_n), 64'h110);
    end else begin
      check(tea_n == 1 && aack_n == 1 && ta_n == 0, "R7", "illegal write error",
            64'(tea_n * 256 + aack_n * 16 + ta_n), 64'h110);
      check(we_falls == 0, "R7", "no strobe on illegal write", 64'(we_falls), 64'd0);
    end
    if (stall != 0)
      check(strobe_viol == 0, "R8", "strobes during PCI", 64'(strobe_viol), 64'd0);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] a;
    int kind;
    oe_cycles = 0; we_falls = 0; strobe_viol = 0; wr_ad = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(rom_oe_n && rom_we_n && !rom_ad_oe && !host_ta && !host_aack && !host_tea,
          "R10", "reset state", {58'd0, rom_oe_n, rom_we_n, rom_ad_oe, host_ta, host_aack, host_tea},
          64'h30);
    rst_n = 1'b1;
    @(negedge clk);
    check(rom_oe_n && rom_we_n && !host_ta, "R10", "after reset release",
          {61'd0, rom_oe_n, rom_we_n, host_ta}, 64'h6);

    // directed corners
    run_txn(32'hFFF0_0100, 0, 4'd8, 0, '0, 0, 0);   // R4 single, big-endian
    run_txn(32'hFFF0_0100, 0, 4'd8, 0, '0, 1, 0);   // R3 little-endian
    run_txn(32'hFFF0_0100, 0, 4'd8, 1, '0, 0, 0);   // R5 burst
    run_txn(32'hFF80_0107, 0, 4'd1, 0, '0, 0, 0);   // R2 alias + low bits ignored
    run_txn(32'hFFF8_0100, 0, 4'd3, 0, '0, 0, 0);   // R2 alias of same device offset
    run_txn(32'hFFFF_FFF0, 1, 4'd4, 0, 32'h00AB_CDEF, 0, 0); // R6 example split
    run_txn(32'hFFFF_FFF1, 1, 4'd4, 0, 32'h1234_5678, 0, 0); // R7 odd address
    run_txn(32'hFFFF_FFF0, 1, 4'd4, 1, 32'h1234_5678, 0, 0); // R7 burst write
    run_txn(32'hFFFF_FFF0, 1, 4'd2, 0, 32'h1234_5678, 0, 0); // R7 wrong size
    run_txn(32'h8000_0000, 0, 4'd8, 0, '0, 0, 0);   // R1 outside window
    run_txn(32'hFF7F_FFF8, 1, 4'd4, 0, 32'hAAAA_AAAA, 0, 0); // R1 just below window
    run_txn(32'hFFC0_1238, 0, 4'd8, 1, '0, 1, 1);   // R8 stalled burst
    run_txn(32'hFFC0_2000, 1, 4'd4, 0, 32'h0012_3499, 0, 2); // R8 stalled write

    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      kind = $urandom % 10;
      a = {9'h1FF, 23'($urandom)};
      case (kind)
        0: run_txn({1'b0, 31'($urandom)}, 1'($urandom), 4'd4, 0, $urandom, 0, 0);
        1, 2, 3, 4, 5: run_txn(a, 0, 4'($urandom), 1'($urandom), '0, 1'($urandom),
                               ($urandom % 2 == 0) ? 1 : 0);
        6, 7: run_txn({a[31:1], 1'b0}, 1, 4'd4, 0, $urandom, 0,
                      ($urandom % 2 == 0) ? 2 : 0);
        default: begin
          if ($urandom % 2 == 0) run_txn({a[31:1], 1'b1}, 1, 4'd4, 0, $urandom, 0, 0);
          else run_txn({a[31:1], 1'b0}, 1, 4'd4, 1, $urandom, 0, 0);
        end
      endcase
    end
    check(strobe_viol == 0, "R8", "no strobe while PCI busy overall", 64'(strobe_viol), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule